// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects an 8-bit CPU data-memory port to a set of external pins. The pins carry a high address byte, a low byte that is shared between address and data, an address-strobe line for an external transparent latch, and active-low read and write strobes. Each CPU request is classified by address. Addresses above a parameterised internal-memory top are external and run a full bus cycle. Addresses at or below that top are internal. An internal access still shows its address on the pins for one clock, but both strobes stay idle.

An external cycle runs through named states. ST_IDLE accepts a request. ST_ADDR raises the address strobe and drives both address bytes. ST_HOLD lowers the address strobe while the low address byte stays on the shared pins, so the latch gets hold time. ST_STROBE asserts the read or write strobe for 1 + N clocks, where N is a wait count from 0 to 3. ST_INT is the single clock of an internal access.

The transitions are:
- ST_IDLE to ST_ADDR on an accepted external request.
- ST_IDLE to ST_INT on an accepted internal request.
- ST_ADDR to ST_HOLD always.
- ST_HOLD to ST_STROBE always.
- ST_STROBE to ST_IDLE when the wait counter reaches zero.
- ST_INT to ST_IDLE always.

While the interface is enabled, it takes over the pin values and output enables that the normal port logic would otherwise set. While it is disabled, the port settings pass through unchanged. In that mode an external address is reported as unmapped and starts no cycle.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, with the interface enabled, ALE is low, RD_n and WR_n are high, cpu_ready is high and cpu_rdata is 0.
- R2: An address greater than SRAM_TOP (default 16'h21FF) starts an external cycle. An address less than or equal to SRAM_TOP starts an internal access.
- R3: An external cycle begins one clock after acceptance. The first clock has ALE high, the low address on pad_ad_o and the high address on pad_ah_o. The next clock has ALE low with the low address still on pad_ad_o. Then comes the strobe phase. On a write, WR_n is low and pad_ad_o carries the write data. The high address stays on pad_ah_o throughout the cycle.
- R4: During a read strobe phase, pad_ad_oe is all zeros. pad_ad_i is captured on the last clock edge of that phase and appears on cpu_rdata afterwards.
- R5: The strobe phase lasts 1 + cfg_wait clocks. cpu_ready is low from the clock after acceptance until the cycle returns to idle, which is 3 + cfg_wait clocks.
- R6: An enabled internal access raises ALE for exactly one clock, with the address on pad_ad_o and pad_ah_o. RD_n and WR_n stay high, and cpu_ready is low for that one clock.
- R7: While enabled, pad_ah_oe and pad_ctl_oe are all ones. pad_ad_oe is all ones except during a read strobe phase. The control-pin bits are ordered bit 0 = ALE, bit 1 = RD_n, bit 2 = WR_n.
- R8: While disabled, every pad value and output enable equals the matching port input, and requests cause no pin activity.
- R9: While disabled, a request to an address above SRAM_TOP raises cpu_unmapped in the same cycle and runs no cycle. A request to an internal address does not raise it.
- R10: While enabled, RD_n and WR_n are never low together, and neither is low while ALE is high.
- R11: Write data on pad_ad_o stays constant for the whole write strobe phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Interface enable |
| cfg_wait | input | 2 | Wait count for the strobe phase |
| cpu_req | input | 1 | Access request, accepted when cpu_ready is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Access address |
| cpu_wdata | input | 8 | Write data |
| cpu_ready | output | 1 | High when idle and able to accept a request |
| cpu_rdata | output | 8 | Last captured external read data |
| cpu_unmapped | output | 1 | External address requested while disabled |
| port_ad_o | input | 8 | Normal port value for the shared byte pins |
| port_ad_oe | input | 8 | Normal port direction for the shared byte pins |
| port_ah_o | input | 8 | Normal port value for the high address pins |
| port_ah_oe | input | 8 | Normal port direction for the high address pins |
| port_ctl_o | input | 3 | Normal port value for the control pins |
| port_ctl_oe | input | 3 | Normal port direction for the control pins |
| pad_ad_i | input | 8 | Input from the shared byte pins |
| pad_ad_o | output | 8 | Shared byte pin value |
| pad_ad_oe | output | 8 | Shared byte pin output enable |
| pad_ah_o | output | 8 | High address pin value |
| pad_ah_oe | output | 8 | High address pin output enable |
| pad_ctl_o | output | 3 | Control pin values {WR_n, RD_n, ALE} |
| pad_ctl_oe | output | 3 | Control pin output enables |

## Verification
The assertions check on every clock that the strobes are exclusive, that neither strobe is low while ALE is high, and that a strobe is preceded by an ALE-low hold clock. They also check that the shared byte is released during reads, that write data is stable, that the high and control pins are overridden while enabled, and that internal accesses never move a strobe. The bench scenarios show the rest. They include the exact phase lengths for every wait count and the address-boundary classification. They also cover round trips through a latch-and-memory model, the pass-through of port settings while disabled, and the unmapped flag.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_STROBE,
        ST_INT
    } xbus_state_e;

    // control pin bit order, decoded by board wiring
    localparam int CTL_ALE = 0;
    localparam int CTL_RD  = 1;
    localparam int CTL_WR  = 2;
    localparam int CTL_N   = 3;
endpackage

// File: rtl/xbus_decode.sv
module xbus_decode #(
    parameter int          AW       = 16,
    parameter logic [15:0] SRAM_TOP = 16'h21FF
) (
    input  logic          en,
    input  logic          req,
    input  logic          idle,
    input  logic [AW-1:0] addr,
    output logic          go_ext,
    output logic          go_int,
    output logic          unmapped
);
    logic is_ext;

    always_comb begin
        is_ext   = (addr > AW'(SRAM_TOP));
        go_ext   = req && idle && en && is_ext;
        go_int   = req && idle && en && !is_ext;
        unmapped = req && !en && is_ext;
    end
endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int WW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_ext,
    input  logic             go_int,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [WW-1:0]    wait_cfg,
    input  logic [DW-1:0]    ad_i,
    output logic [DW-1:0]    bus_ad_o,
    output logic             bus_ad_oe,
    output logic [AW-DW-1:0] bus_ah_o,
    output logic [CTL_N-1:0] bus_ctl,
    output logic             ready,
    output logic [DW-1:0]    rdata
);
    xbus_state_e   state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, rdata_q;
    logic          we_q;
    logic [WW-1:0] wcnt_q;
    logic          last_strobe;

    assign last_strobe = (state_q == ST_STROBE) && (wcnt_q == '0);
    assign rdata       = rdata_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go_ext) state_d = ST_ADDR;
                       else if (go_int) state_d = ST_INT;
            ST_ADDR:   state_d = ST_HOLD;
            ST_HOLD:   state_d = ST_STROBE;
            ST_STROBE: if (wcnt_q == '0) state_d = ST_IDLE;
            ST_INT:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // access context and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            we_q    <= 1'b0;
            wcnt_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && (go_ext || go_int)) begin
                addr_q  <= addr;
                wdata_q <= wdata;
                we_q    <= we;
                wcnt_q  <= wait_cfg;
            end
            if (state_q == ST_STROBE && wcnt_q != '0)
                wcnt_q <= wcnt_q - 1'b1;
            if (last_strobe && !we_q)
                rdata_q <= ad_i;
        end
    end

    // outputs
    always_comb begin
        bus_ad_o         = addr_q[DW-1:0];
        bus_ad_oe        = 1'b1;
        bus_ah_o         = addr_q[AW-1:DW];
        bus_ctl          = '0;
        bus_ctl[CTL_RD]  = 1'b1;
        bus_ctl[CTL_WR]  = 1'b1;
        ready            = 1'b0;
        unique case (state_q)
            ST_IDLE:   ready = 1'b1;
            ST_ADDR:   bus_ctl[CTL_ALE] = 1'b1;
            ST_HOLD:   ;
            ST_STROBE: begin
                if (we_q) begin
                    bus_ctl[CTL_WR] = 1'b0;
                    bus_ad_o        = wdata_q;
                end else begin
                    bus_ctl[CTL_RD] = 1'b0;
                    bus_ad_oe       = 1'b0;
                end
            end
            ST_INT:    bus_ctl[CTL_ALE] = 1'b1;
            default:   ;
        endcase
    end

    AST_WAIT_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STROBE && wcnt_q != '0) |=> (state_q == ST_STROBE)); // R5
    AST_ADDR_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR) |=> (state_q == ST_HOLD && bus_ctl[CTL_ALE] == 1'b0)); // R3
endmodule

// File: rtl/xbus_pinmux.sv
module xbus_pinmux
    import xbus_pkg::*;
#(
    parameter int DW = 8,
    parameter int HW = 8
) (
    input  logic             en,
    input  logic [DW-1:0]    bus_ad_o,
    input  logic             bus_ad_oe,
    input  logic [HW-1:0]    bus_ah_o,
    input  logic [CTL_N-1:0] bus_ctl,
    input  logic [DW-1:0]    port_ad_o,
    input  logic [DW-1:0]    port_ad_oe,
    input  logic [HW-1:0]    port_ah_o,
    input  logic [HW-1:0]    port_ah_oe,
    input  logic [CTL_N-1:0] port_ctl_o,
    input  logic [CTL_N-1:0] port_ctl_oe,
    output logic [DW-1:0]    pad_ad_o,
    output logic [DW-1:0]    pad_ad_oe,
    output logic [HW-1:0]    pad_ah_o,
    output logic [HW-1:0]    pad_ah_oe,
    output logic [CTL_N-1:0] pad_ctl_o,
    output logic [CTL_N-1:0] pad_ctl_oe
);
    assign pad_ad_o  = en ? bus_ad_o         : port_ad_o;
    assign pad_ad_oe = en ? {DW{bus_ad_oe}}  : port_ad_oe;
    assign pad_ah_o  = en ? bus_ah_o         : port_ah_o;
    assign pad_ah_oe = en ? {HW{1'b1}}       : port_ah_oe;

    for (genvar g = 0; g < CTL_N; g++) begin : g_ctl
        assign pad_ctl_o[g]  = en ? bus_ctl[g] : port_ctl_o[g];
        assign pad_ctl_oe[g] = en ? 1'b1       : port_ctl_oe[g];
    end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          DW       = 8,
    parameter int          WW       = 2,
    parameter logic [15:0] SRAM_TOP = 16'h21FF,
    localparam int         HW       = AW - DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic [WW-1:0]    cfg_wait,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [DW-1:0]    cpu_wdata,
    output logic             cpu_ready,
    output logic [DW-1:0]    cpu_rdata,
    output logic             cpu_unmapped,
    input  logic [DW-1:0]    port_ad_o,
    input  logic [DW-1:0]    port_ad_oe,
    input  logic [HW-1:0]    port_ah_o,
    input  logic [HW-1:0]    port_ah_oe,
    input  logic [CTL_N-1:0] port_ctl_o,
    input  logic [CTL_N-1:0] port_ctl_oe,
    input  logic [DW-1:0]    pad_ad_i,
    output logic [DW-1:0]    pad_ad_o,
    output logic [DW-1:0]    pad_ad_oe,
    output logic [HW-1:0]    pad_ah_o,
    output logic [HW-1:0]    pad_ah_oe,
    output logic [CTL_N-1:0] pad_ctl_o,
    output logic [CTL_N-1:0] pad_ctl_oe
);
    logic             go_ext, go_int;
    logic [DW-1:0]    bus_ad_o;
    logic             bus_ad_oe;
    logic [HW-1:0]    bus_ah_o;
    logic [CTL_N-1:0] bus_ctl;

    xbus_decode #(.AW(AW), .SRAM_TOP(SRAM_TOP)) u_decode (
        .en(cfg_enable), .req(cpu_req), .idle(cpu_ready), .addr(cpu_addr),
        .go_ext(go_ext), .go_int(go_int), .unmapped(cpu_unmapped)
    );

    xbus_fsm #(.AW(AW), .DW(DW), .WW(WW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go_ext(go_ext), .go_int(go_int),
        .we(cpu_we), .addr(cpu_addr), .wdata(cpu_wdata), .wait_cfg(cfg_wait),
        .ad_i(pad_ad_i), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
        .bus_ah_o(bus_ah_o), .bus_ctl(bus_ctl), .ready(cpu_ready), .rdata(cpu_rdata)
    );

    xbus_pinmux #(.DW(DW), .HW(HW)) u_pinmux (
        .en(cfg_enable), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
        .bus_ah_o(bus_ah_o), .bus_ctl(bus_ctl),
        .port_ad_o(port_ad_o), .port_ad_oe(port_ad_oe),
        .port_ah_o(port_ah_o), .port_ah_oe(port_ah_oe),
        .port_ctl_o(port_ctl_o), .port_ctl_oe(port_ctl_oe),
        .pad_ad_o(pad_ad_o), .pad_ad_oe(pad_ad_oe),
        .pad_ah_o(pad_ah_o), .pad_ah_oe(pad_ah_oe),
        .pad_ctl_o(pad_ctl_o), .pad_ctl_oe(pad_ctl_oe)
    );

    logic strobe_low;
    assign strobe_low = !(pad_ctl_o[CTL_RD] && pad_ctl_o[CTL_WR]);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enable |-> (pad_ctl_o[CTL_RD] || pad_ctl_o[CTL_WR])); // R10
    AST_NO_STROBE_UNDER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && pad_ctl_o[CTL_ALE]) |-> !strobe_low); // R10
    AST_HOLD_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && $rose(strobe_low)) |-> ($past(pad_ctl_o[CTL_ALE]) == 1'b0)); // R3
    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && !pad_ctl_o[CTL_RD]) |-> (pad_ad_oe == '0)); // R4
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && !pad_ctl_o[CTL_WR] && $past(!pad_ctl_o[CTL_WR])) |-> $stable(pad_ad_o)); // R11
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_low && cfg_enable |-> !cpu_ready); // R5
    AST_OVERRIDE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enable |-> ((&pad_ah_oe) && (&pad_ctl_oe))); // R7
    AST_INT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        go_int |=> (pad_ctl_o[CTL_RD] && pad_ctl_o[CTL_WR] && pad_ctl_o[CTL_ALE])); // R6
    AST_UNMAPPED_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_unmapped && cpu_ready |=> cpu_ready); // R9
endmodule

// File: tb/test_xbus_ctrl.sv
module test_xbus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b1;
    logic [1:0]  cfg_wait = '0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_ready, cpu_unmapped;
    logic [7:0]  cpu_rdata;
    logic [7:0]  port_ad_o = 8'h3C, port_ad_oe = 8'h0F, port_ah_o = 8'hA5, port_ah_oe = 8'h81;
    logic [2:0]  port_ctl_o = 3'b011, port_ctl_oe = 3'b101;
    logic [7:0]  pad_ad_i, pad_ad_o, pad_ad_oe, pad_ah_o, pad_ah_oe;
    logic [2:0]  pad_ctl_o, pad_ctl_oe;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    bit int_mode = 0;
    int int_strobes = 0;

    always #2.5 clk = ~clk; // 200 MHz

    xbus_ctrl i_xbus_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_wait(cfg_wait),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_unmapped(cpu_unmapped),
        .port_ad_o(port_ad_o), .port_ad_oe(port_ad_oe), .port_ah_o(port_ah_o),
        .port_ah_oe(port_ah_oe), .port_ctl_o(port_ctl_o), .port_ctl_oe(port_ctl_oe),
        .pad_ad_i(pad_ad_i), .pad_ad_o(pad_ad_o), .pad_ad_oe(pad_ad_oe),
        .pad_ah_o(pad_ah_o), .pad_ah_oe(pad_ah_oe),
        .pad_ctl_o(pad_ctl_o), .pad_ctl_oe(pad_ctl_oe)
    );

    // external latch (transparent while ALE high) and memory
    logic [7:0] lat;
    logic [7:0] sram [0:65535];
    always_latch if (pad_ctl_o[0]) lat = pad_ad_o;
    always @(negedge clk) if (cfg_enable && !pad_ctl_o[2]) sram[{pad_ah_o, lat}] <= pad_ad_o;
    assign pad_ad_i = !pad_ctl_o[1] ? sram[{pad_ah_o, lat}] : 8'h00;
    always @(negedge clk) if (int_mode && (!pad_ctl_o[1] || !pad_ctl_o[2])) int_strobes++;

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic t_reset();
        chk(pad_ctl_o == 3'b110, "R1 ctl", pad_ctl_o, 3'b110);
        chk(cpu_ready == 1'b1, "R1 ready", cpu_ready, 1);
        chk(cpu_rdata == 8'h00, "R1 rdata", cpu_rdata, 0);
    endtask

    task automatic t_ext_write(input logic [15:0] a, input logic [7:0] d, input int w);
        @(negedge clk);
        cfg_wait = w[1:0]; cpu_addr = a; cpu_we = 1'b1; cpu_wdata = d; cpu_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
        chk(pad_ctl_o == 3'b111 && pad_ad_o == a[7:0] && pad_ah_o == a[15:8], "R3 addr phase",
            {pad_ctl_o, pad_ah_o, pad_ad_o}, {3'b111, a});
        chk(!cpu_ready, "R5 busy", cpu_ready, 0);
        @(negedge clk);
        chk(pad_ctl_o == 3'b110 && pad_ad_o == a[7:0], "R3 hold phase", {pad_ctl_o, pad_ad_o}, {3'b110, a[7:0]});
        for (int i = 0; i <= w; i++) begin
            @(negedge clk);
            chk(pad_ctl_o == 3'b010 && pad_ad_o == d && pad_ah_o == a[15:8], "R3 R11 write strobe",
                {pad_ctl_o, pad_ah_o, pad_ad_o}, {3'b010, a[15:8], d});
            chk(pad_ad_oe == 8'hFF && pad_ah_oe == 8'hFF && pad_ctl_oe == 3'b111, "R7 oe",
                {pad_ctl_oe, pad_ah_oe, pad_ad_oe}, 19'h7FFFF);
            chk(!cpu_ready, "R5 busy", cpu_ready, 0);
        end
        @(negedge clk);
        chk(cpu_ready && pad_ctl_o == 3'b110, "R5 end", {cpu_ready, pad_ctl_o}, 4'b1110);
        chk(sram[a] == d, "R3 memory", sram[a], d);
    endtask

    task automatic t_ext_read(input logic [15:0] a, input logic [7:0] exp, input int w);
        @(negedge clk);
        cfg_wait = w[1:0]; cpu_addr = a; cpu_we = 1'b0; cpu_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
        chk(pad_ctl_o == 3'b111 && pad_ad_o == a[7:0], "R2 R3 addr phase", {pad_ctl_o, pad_ad_o}, {3'b111, a[7:0]});
        @(negedge clk);
        chk(pad_ctl_o == 3'b110, "R3 hold", pad_ctl_o, 3'b110);
        for (int i = 0; i <= w; i++) begin
            @(negedge clk);
            chk(pad_ctl_o == 3'b100 && pad_ad_oe == 8'h00, "R4 R10 read strobe",
                {pad_ctl_o, pad_ad_oe}, {3'b100, 8'h00});
        end
        @(negedge clk);
        chk(cpu_ready && pad_ctl_o == 3'b110, "R5 end", {cpu_ready, pad_ctl_o}, 4'b1110);
        chk(cpu_rdata == exp, "R4 rdata", cpu_rdata, exp);
    endtask

    task automatic t_internal(input logic [15:0] a, input logic we);
        int_mode = 1; int_strobes = 0;
        @(negedge clk);
        cfg_wait = 2'd3; cpu_addr = a; cpu_we = we; cpu_wdata = 8'hEE; cpu_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
        chk(pad_ctl_o == 3'b111 && pad_ad_o == a[7:0] && pad_ah_o == a[15:8] && !cpu_ready,
            "R2 R6 internal", {cpu_ready, pad_ctl_o, pad_ah_o, pad_ad_o}, {1'b0, 3'b111, a});
        @(negedge clk);
        chk(cpu_ready && pad_ctl_o == 3'b110, "R6 one clock", {cpu_ready, pad_ctl_o}, 4'b1110);
        repeat (3) @(negedge clk);
        int_mode = 0;
        chk(int_strobes == 0, "R6 no strobe", int_strobes, 0);
    endtask

    task automatic t_disabled();
        @(negedge clk);
        cfg_enable = 1'b0;
        #1;
        chk({pad_ad_o, pad_ad_oe, pad_ah_o, pad_ah_oe, pad_ctl_o, pad_ctl_oe} ==
            {port_ad_o, port_ad_oe, port_ah_o, port_ah_oe, port_ctl_o, port_ctl_oe}, "R8 passthrough",
            {pad_ad_o, pad_ah_o, pad_ctl_o}, {port_ad_o, port_ah_o, port_ctl_o});
        @(negedge clk);
        cpu_addr = 16'h2200; cpu_we = 1'b1; cpu_req = 1'b1;
        #1;
        chk(cpu_unmapped == 1'b1, "R9 unmapped", cpu_unmapped, 1);
        @(negedge clk);
        cpu_req = 1'b0;
        chk(cpu_ready && pad_ctl_o == port_ctl_o && pad_ad_o == port_ad_o, "R8 R9 no cycle",
            {cpu_ready, pad_ctl_o, pad_ad_o}, {1'b1, port_ctl_o, port_ad_o});
        cpu_addr = 16'h21FF; cpu_req = 1'b1;
        #1;
        chk(cpu_unmapped == 1'b0, "R9 internal not unmapped", cpu_unmapped, 0);
        @(negedge clk);
        cpu_req = 1'b0;
        chk(cpu_ready && pad_ctl_o == port_ctl_o, "R8 internal quiet", {cpu_ready, pad_ctl_o}, {1'b1, port_ctl_o});
        port_ctl_o = 3'b100; port_ad_o = 8'h99;
        #1;
        chk(pad_ctl_o == 3'b100 && pad_ad_o == 8'h99, "R8 follows port", {pad_ctl_o, pad_ad_o}, {3'b100, 8'h99});
        @(negedge clk);
        cfg_enable = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ext_write(16'h2200, 8'hC3, 0);
        t_ext_read (16'h2200, 8'hC3, 0);
        t_ext_write(16'hFFFF, 8'h5A, 3);
        t_ext_read (16'hFFFF, 8'h5A, 3);
        t_ext_write(16'h8034, 8'h17, 1);
        t_ext_read (16'h8034, 8'h17, 2);
        t_internal (16'h21FF, 1'b1);
        t_internal (16'h0100, 1'b0);
        t_disabled();
        t_ext_read (16'h2200, 8'hC3, 1);
        done = 1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            summary();
        end
    end
endmodule